// File: doc/BRIEF.md
# CRT Sync and Blank Output Stage

This block sits between a display timing generator and the pins of a CRT connector. The timing generator supplies three active-high strobes: a horizontal retrace strobe, a vertical retrace strobe and a blanking strobe. The block turns these into the HSYNC, VSYNC and active-low BLANK# pins. For each pin it applies a separate polarity control and a separate power-management enable.

A disabled pin is driven to a static low level, whatever its polarity, which is how display power-saving states are reached. When the vertical sync pin is disabled, a software-controlled serial clock bit drives that pin instead, so software can clock monitor identification data over the vertical sync wire.

The block also produces three other outputs:
- A vertical interrupt flag that sets on the next rising edge of the vertical strobe and stays set until its enable is cleared.
- A blink phase that toggles after a selectable number of frames.
- A reset for the dot-clock domain and a lock on writes to the timing registers, both driven by the timing-generator enable.

All configuration arrives as static inputs from a register elsewhere. Every output is registered on the dot clock, so each one reflects the inputs present at the previous rising edge.

Top module: `crt_sync_out`

## Requirements
- R1: With `hs_en_i`=1, `hsync_o` equals `hs_raw_i` when `hs_pol_i`=0 and its inverse when `hs_pol_i`=1, one clock after the inputs.
- R2: With `vs_en_i`=1, `vsync_o` equals `vs_raw_i` when `vs_pol_i`=0 and its inverse when `vs_pol_i`=1, independent of `hs_pol_i`, one clock after the inputs.
- R3: With `hs_en_i`=0, `hsync_o` is 0 one clock later, for any `hs_raw_i` and `hs_pol_i`.
- R4: With `blank_en_i`=1, `blank_n_o` is the inverse of `blank_raw_i`; with `blank_en_i`=0 it is 0, one clock later.
- R5: With `vs_en_i`=0, `vsync_o` follows `ddc_clk_i` one clock later, for any `vs_raw_i` and `vs_pol_i`.
- R6: With `vint_en_i`=1 and `tgen_en_i`=1, a 0-to-1 transition of `vs_raw_i` between two sampling edges sets `vint_o` at the edge that sees the 1. `vint_o` then stays 1 while `vint_en_i` stays 1.
- R7: With `vint_en_i`=0, `vint_o` is 0 one clock later, and rising edges of `vs_raw_i` do not set it.
- R8: `dot_rst_o` is the inverse of `tgen_en_i` one clock later. `tmg_wr_ack_o` is `tmg_wr_req_i` while `tgen_en_i`=0 and is 0 while `tgen_en_i`=1, one clock later.
- R9: With `blink_en_i`=1 and `tgen_en_i`=1, `blink_o` toggles at the 16th counted rising edge of `vs_raw_i` when `blink_rate_i`=0, and at the 32nd when `blink_rate_i`=1. If the count is already at or beyond the limit, the next edge toggles `blink_o` and restarts the count. With `blink_en_i`=0, `blink_o` is 0 and the frame count restarts from zero.
- R10: While `tgen_en_i`=0, `blink_o` is 0, the frame count is zero, and rising edges of `vs_raw_i` neither set `vint_o` nor advance the count. An edge is counted when the strobe is already 1 at the first edge with `tgen_en_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_raw_i | input | 1 | Active-high horizontal retrace strobe |
| vs_raw_i | input | 1 | Active-high vertical retrace strobe |
| blank_raw_i | input | 1 | Active-high blanking strobe |
| hs_pol_i | input | 1 | 1 inverts horizontal sync |
| vs_pol_i | input | 1 | 1 inverts vertical sync |
| hs_en_i | input | 1 | Horizontal sync pin enable |
| vs_en_i | input | 1 | Vertical sync pin enable |
| blank_en_i | input | 1 | Blank pin enable |
| ddc_clk_i | input | 1 | Software serial clock bit for the vertical sync pin |
| blink_en_i | input | 1 | Blink enable |
| blink_rate_i | input | 1 | 0: 16 frames per phase, 1: 32 frames |
| vint_en_i | input | 1 | Vertical interrupt enable; 0 clears the flag |
| tgen_en_i | input | 1 | Timing generator enable |
| tmg_wr_req_i | input | 1 | Write request to the timing registers |
| hsync_o | output | 1 | HSYNC pin |
| vsync_o | output | 1 | VSYNC pin |
| blank_n_o | output | 1 | BLANK# pin |
| blink_o | output | 1 | Blink phase |
| vint_o | output | 1 | Sticky vertical interrupt flag |
| dot_rst_o | output | 1 | Dot-clock domain reset |
| tmg_wr_ack_o | output | 1 | Timing register write permitted |

## Verification
Every strobe value is applied under each polarity. With the outputs enabled, this separates a correct inversion from a missing or swapped one. Setting the two polarities to opposite values shows whether the horizontal and vertical controls are crossed. The same strobes are applied with each enable cleared; a static low, as opposed to a polarity-dependent level, shows that gating is applied after inversion. Toggling the serial clock while vertical sync is disabled shows the pin follows that bit and not the strobe. Long runs of vertical pulses at both blink rates, a pulse landing while the generator is off, and a strobe already high when it turns on, separate the 16-frame and 32-frame periods and show whether edges are gated by the timing-generator enable.

// File: rtl/crt_out_pkg.sv
package crt_out_pkg;
    localparam int PIN_COUNT = 3;
    localparam int PIN_HSYNC = 0;
    localparam int PIN_VSYNC = 1;
    localparam int PIN_BLANK = 2;

    typedef struct packed {
        logic dot_rst;
        logic wr_ack;
    } ctl_regs_t;
endpackage

// File: rtl/crt_pin_cell.sv
module crt_pin_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic invert_i,
    input  logic enable_i,
    input  logic alt_i,
    output logic pin_o
);
    logic pin_d, pin_q;

    always_comb begin
        if (enable_i) pin_d = raw_i ^ invert_i;
        else          pin_d = alt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= RST_VAL;
        else        pin_q <= pin_d;
    end

    assign pin_o = pin_q;

    // R3 / R5: a disabled pin shows its substitute level (low, or the serial clock)
    assert_off_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(enable_i)) |-> (pin_o == $past(alt_i)));

    // R1 / R2 / R4: an enabled pin carries the strobe under the chosen polarity
    assert_on_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(enable_i)) |-> (pin_o == ($past(raw_i) ^ $past(invert_i))));
endmodule

// File: rtl/crt_vint_flag.sv
module crt_vint_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic vs_raw_i,
    input  logic vint_en_i,
    output logic vs_rise_o,
    output logic irq_o
);
    typedef struct packed {
        logic vs_prev;
        logic irq;
    } vint_regs_t;

    vint_regs_t r_d, r_q;
    logic rise;

    always_comb begin
        rise        = run_i & vs_raw_i & ~r_q.vs_prev;
        r_d.vs_prev = run_i & vs_raw_i;
        r_d.irq     = vint_en_i & (r_q.irq | rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign vs_rise_o = rise;
    assign irq_o     = r_q.irq;

    assert_irq_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(vint_en_i)) |-> !irq_o);

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(irq_o) && $past(vint_en_i)) |-> irq_o);

    assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vs_rise_o) && $past(vint_en_i)) |-> irq_o);

    assert_no_edge_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !vs_rise_o);
endmodule

// File: rtl/crt_blink_gen.sv
module crt_blink_gen #(
    parameter int FAST_FRAMES = 16,
    parameter int SLOW_FRAMES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic blink_en_i,
    input  logic rate_i,
    input  logic vs_rise_i,
    output logic phase_o
);
    localparam int MAX_FRAMES = (SLOW_FRAMES > FAST_FRAMES) ? SLOW_FRAMES : FAST_FRAMES;
    localparam int CNT_W      = (MAX_FRAMES > 2) ? $clog2(MAX_FRAMES) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } blink_regs_t;

    blink_regs_t r_d, r_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt = rate_i ? CNT_W'(SLOW_FRAMES - 1) : CNT_W'(FAST_FRAMES - 1);
        r_d      = r_q;
        if (!run_i || !blink_en_i) begin
            r_d = '0;
        end else if (vs_rise_i) begin
            if (r_q.cnt >= last_cnt) begin
                r_d.cnt   = '0;
                r_d.phase = ~r_q.phase;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign phase_o = r_q.phase;

    assert_phase_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(vs_rise_i) && $past(blink_en_i) && $past(run_i)) |-> $stable(phase_o));

    assert_phase_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(run_i)) |-> !phase_o);
endmodule

// File: rtl/crt_sync_out.sv
module crt_sync_out #(
    parameter int FAST_FRAMES = 16,
    parameter int SLOW_FRAMES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_raw_i,
    input  logic vs_raw_i,
    input  logic blank_raw_i,
    input  logic hs_pol_i,
    input  logic vs_pol_i,
    input  logic hs_en_i,
    input  logic vs_en_i,
    input  logic blank_en_i,
    input  logic ddc_clk_i,
    input  logic blink_en_i,
    input  logic blink_rate_i,
    input  logic vint_en_i,
    input  logic tgen_en_i,
    input  logic tmg_wr_req_i,
    output logic hsync_o,
    output logic vsync_o,
    output logic blank_n_o,
    output logic blink_o,
    output logic vint_o,
    output logic dot_rst_o,
    output logic tmg_wr_ack_o
);
    import crt_out_pkg::*;

    logic [PIN_COUNT-1:0] pin_raw, pin_inv, pin_en, pin_alt, pin_out;
    logic vs_rise;
    ctl_regs_t ctl_d, ctl_q;

    always_comb begin
        pin_raw[PIN_HSYNC] = hs_raw_i;
        pin_inv[PIN_HSYNC] = hs_pol_i;
        pin_en [PIN_HSYNC] = hs_en_i;
        pin_alt[PIN_HSYNC] = 1'b0;
        pin_raw[PIN_VSYNC] = vs_raw_i;
        pin_inv[PIN_VSYNC] = vs_pol_i;
        pin_en [PIN_VSYNC] = vs_en_i;
        pin_alt[PIN_VSYNC] = ddc_clk_i;
        pin_raw[PIN_BLANK] = blank_raw_i;
        pin_inv[PIN_BLANK] = 1'b1;
        pin_en [PIN_BLANK] = blank_en_i;
        pin_alt[PIN_BLANK] = 1'b0;
    end

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
        crt_pin_cell #(.RST_VAL(1'b0)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (pin_raw[p]),
            .invert_i (pin_inv[p]),
            .enable_i (pin_en[p]),
            .alt_i    (pin_alt[p]),
            .pin_o    (pin_out[p])
        );
    end

    assign hsync_o   = pin_out[PIN_HSYNC];
    assign vsync_o   = pin_out[PIN_VSYNC];
    assign blank_n_o = pin_out[PIN_BLANK];

    crt_vint_flag u_vint (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tgen_en_i),
        .vs_raw_i  (vs_raw_i),
        .vint_en_i (vint_en_i),
        .vs_rise_o (vs_rise),
        .irq_o     (vint_o)
    );

    crt_blink_gen #(
        .FAST_FRAMES (FAST_FRAMES),
        .SLOW_FRAMES (SLOW_FRAMES)
    ) u_blink (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (tgen_en_i),
        .blink_en_i (blink_en_i),
        .rate_i     (blink_rate_i),
        .vs_rise_i  (vs_rise),
        .phase_o    (blink_o)
    );

    always_comb begin
        ctl_d.dot_rst = ~tgen_en_i;
        ctl_d.wr_ack  = tmg_wr_req_i & ~tgen_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.dot_rst <= 1'b1;
            ctl_q.wr_ack  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dot_rst_o    = ctl_q.dot_rst;
    assign tmg_wr_ack_o = ctl_q.wr_ack;

    assert_wr_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tgen_en_i)) |-> (!tmg_wr_ack_o && !dot_rst_o));
endmodule

// File: tb/test_crt_sync_out.sv
module test_crt_sync_out;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_raw = 0, vs_raw = 0, blank_raw = 0;
    logic hs_pol = 0, vs_pol = 0, hs_en = 0, vs_en = 0, blank_en = 0;
    logic ddc_clk = 0, blink_en = 0, blink_rate = 0, vint_en = 0, tgen_en = 0, wr_req = 0;
    logic hsync, vsync, blank_n, blink, vint, dot_rst, wr_ack;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [6:0] exp_q[$];
    string      tag_q[$];

    // independent model state
    logic m_prev = 0, m_irq = 0, m_phase = 0;
    int   m_cnt = 0;

    always #2.5 clk = ~clk;

    crt_sync_out i_crt_sync_out (
        .clk(clk), .rst_n(rst_n),
        .hs_raw_i(hs_raw), .vs_raw_i(vs_raw), .blank_raw_i(blank_raw),
        .hs_pol_i(hs_pol), .vs_pol_i(vs_pol), .hs_en_i(hs_en), .vs_en_i(vs_en),
        .blank_en_i(blank_en), .ddc_clk_i(ddc_clk), .blink_en_i(blink_en),
        .blink_rate_i(blink_rate), .vint_en_i(vint_en), .tgen_en_i(tgen_en),
        .tmg_wr_req_i(wr_req),
        .hsync_o(hsync), .vsync_o(vsync), .blank_n_o(blank_n), .blink_o(blink),
        .vint_o(vint), .dot_rst_o(dot_rst), .tmg_wr_ack_o(wr_ack)
    );

    function automatic logic [6:0] outs();
        return {hsync, vsync, blank_n, blink, vint, dot_rst, wr_ack};
    endfunction

    // driver: compute expected for current inputs, queue it, advance one cycle
    task automatic tick(input string tag);
        logic e_hs, e_vs, e_bn, rise;
        int lim;
        e_hs = hs_en ? (hs_raw ^ hs_pol) : 1'b0;
        e_vs = vs_en ? (vs_raw ^ vs_pol) : ddc_clk;
        e_bn = blank_en ? ~blank_raw : 1'b0;
        rise = tgen_en && vs_raw && !m_prev;
        m_prev = tgen_en && vs_raw;
        m_irq = vint_en && (m_irq || rise);
        lim = blink_rate ? 32 : 16;
        if (!blink_en || !tgen_en) begin
            m_cnt = 0; m_phase = 0;
        end else if (rise) begin
            if (m_cnt >= lim - 1) begin m_cnt = 0; m_phase = ~m_phase; end
            else m_cnt++;
        end
        exp_q.push_back({e_hs, e_vs, e_bn, m_phase, m_irq, ~tgen_en, wr_req & ~tgen_en});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [6:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (outs() !== e) begin
                bad++;
                $display("FAIL %s got=%b exp=%b (hs,vs,bn,blink,irq,rst,ack)", t, outs(), e);
            end
        end
    end

    task automatic vpulses(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            vs_raw = 1; tick(tag); tick(tag);
            vs_raw = 0; tick(tag); tick(tag);
        end
    endtask

    initial begin
        #200000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired got=hang exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #12;
        total++;
        if (outs() !== 7'b0000010) begin
            bad++;
            $display("FAIL reset state got=%b exp=%b", outs(), 7'b0000010);
        end
        @(negedge clk); rst_n = 1;
        @(negedge clk);

        // R1 R2 R4: all enabled, polarity sweep
        tgen_en = 1; hs_en = 1; vs_en = 1; blank_en = 1;
        for (int p = 0; p < 4; p++) begin
            hs_pol = p[0]; vs_pol = p[1];
            for (int i = 0; i < 8; i++) begin
                hs_raw = i[0]; vs_raw = i[1]; blank_raw = i[2];
                tick("R1 R2 R4 polarity");
            end
        end

        // R3: horizontal disabled, both polarities
        hs_en = 0;
        for (int i = 0; i < 4; i++) begin
            hs_pol = i[1]; hs_raw = i[0]; tick("R3 hsync off");
        end
        hs_en = 1;

        // R4: blank disabled
        blank_en = 0;
        for (int i = 0; i < 2; i++) begin blank_raw = i[0]; tick("R4 blank off"); end
        blank_en = 1;

        // R5: vsync disabled, serial clock drives pin
        vs_en = 0;
        for (int i = 0; i < 8; i++) begin
            ddc_clk = i[0]; vs_raw = i[1]; vs_pol = i[2]; tick("R5 ddc clock");
        end
        vs_en = 1; vs_pol = 0; vs_raw = 0; ddc_clk = 0;
        tick("R5 restore");

        // R6 R7: vertical interrupt
        vint_en = 1; tick("R6 idle");
        vpulses(1, "R6 set");
        tick("R6 sticky"); tick("R6 sticky");
        vint_en = 0; tick("R7 clear");
        vpulses(1, "R7 masked");
        vint_en = 1; tick("R7 reenable");
        vpulses(1, "R6 second");

        // R8 R10: timing generator off
        wr_req = 1; tick("R8 locked");
        tgen_en = 0; tick("R8 write open");
        vint_en = 0; tick("R10 clear"); vint_en = 1;
        vpulses(2, "R10 no edge while off");
        wr_req = 0; tick("R8 no request");
        vs_raw = 1; tick("R10 strobe held high");
        tgen_en = 1; tick("R10 edge at enable");
        vs_raw = 0; tick("R10 after enable");
        wr_req = 1; tick("R8 locked again"); wr_req = 0;

        // R9: blink fast rate, then slow rate, then disable
        blink_en = 1; blink_rate = 0;
        vpulses(40, "R9 fast blink");
        blink_rate = 1;
        vpulses(70, "R9 slow blink");
        blink_rate = 0;
        vpulses(3, "R9 rate drop");
        blink_en = 0; tick("R9 blink off");
        blink_en = 1;
        vpulses(18, "R9 restart");
        tgen_en = 0; tick("R10 blink cleared");
        vpulses(2, "R10 off");
        tgen_en = 1;
        tick("R10 resume");

        @(negedge clk); @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule